// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the two lowest address bits of a synchronous memory during a four-beat burst. A burst opens when an address strobe is accepted on a rising clock edge. The two low address bits presented at that edge become the starting offset. Each accepted advance request then steps the offset to the next beat. The order is either linear, counting upward modulo four, or interleaved, where the starting offset is XORed with the beat number. A static strap input picks the order.

There are two strobes, a processor strobe and a controller strobe, and both are active low. The processor strobe counts only while the active-low chip enable is asserted. When both strobes are accepted in the same cycle there is still a single load, and it is attributed to the processor strobe. A strobe always takes precedence over an advance request in the same cycle.

The control is a two-state machine.
- `ST_IDLE` is the state after reset, before any burst has been loaded. An advance request does nothing here.
- `ST_BURST` is the state once a burst is loaded.

It has three transitions.
- `T_OPEN` goes from IDLE to BURST on any accepted strobe.
- `T_RELOAD` goes from BURST to BURST on an accepted strobe, and restarts the beat count.
- `T_STEP` goes from BURST to BURST on an advance request without a strobe, and increments the beat count modulo four.

In all other cases the state and the registers hold.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is held, the offset output reads 0 at each clock edge. The machine is in ST_IDLE.
- R2: When `adsc_n` is low at a rising edge, `addr_lo` is loaded, and the offset equals it after that edge in either order.
- R3: When `adsp_n` is low and `ce1_n` is low at a rising edge, `addr_lo` is loaded, and the offset equals it after that edge.
- R4: A low `adsp_n` while `ce1_n` is high is ignored. If no other strobe or advance request is present, the offset is unchanged.
- R5: When both strobes are low together with `ce1_n` low, exactly one load takes place from `addr_lo`. A simultaneous low `adv_n` does not step the offset.
- R6: With `burst_order` = 0 (linear), the k-th advance after a load with start s gives the offset (s + k) mod 4.
- R7: With `burst_order` = 1 (interleaved), the k-th advance after a load with start s gives the offset s XOR (k mod 4).
- R8: After four advances the offset returns to its start value. Further advances keep cycling without a reload.
- R9: With both strobes high and `adv_n` high, the offset holds its value.
- R10: In ST_IDLE (no load since reset), a low `adv_n` has no effect and the offset stays 0.
- R11: With `ce1_n` high, both strobes low loads `addr_lo` through the controller strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adsp_n | input | 1 | Processor address strobe, active low, gated by ce1_n |
| adsc_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable qualifier for the processor strobe, active low |
| adv_n | input | 1 | Advance request, active low |
| burst_order | input | 1 | Static strap: 0 selects linear, 1 selects interleaved |
| addr_lo | input | 2 | Low address bits loaded as the starting offset |
| burst_ofs | output | 2 | Current burst offset |

## Verification
A load and a step can both be requested at the same edge. This is provoked by driving a low `adv_n` in the same cycle as one or both strobes, in the middle of a burst. The result is judged by the offset after the edge: it must equal the freshly loaded address, not the stepped value. The bench also exercises the two strobes together, with the chip enable asserted and with it deasserted, to confirm that exactly one load results.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bseq_state_e;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_PROC = 2'd1,
        LD_CTRL = 2'd2
    } load_src_e;

endpackage

// File: rtl/strobe_arbiter.sv
module strobe_arbiter
    import burst_seq_pkg::*;
(
    input  logic      adsp_n,
    input  logic      adsc_n,
    input  logic      ce1_n,
    output load_src_e load_src
);

    logic proc_ok;
    logic ctrl_ok;

    // Processor strobe is only meaningful while the chip enable is asserted.
    assign proc_ok = !adsp_n && !ce1_n;
    assign ctrl_ok = !adsc_n;

    always_comb begin
        if (proc_ok) begin
            load_src = LD_PROC;
        end else if (ctrl_ok) begin
            load_src = LD_CTRL;
        end else begin
            load_src = LD_NONE;
        end
    end

endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_seq_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  load_src_e        load_src,
    input  logic             adv_n,
    input  logic [OFS_W-1:0] addr_lo,
    output bseq_state_e      state,
    output logic [OFS_W-1:0] start_ofs,
    output logic [OFS_W-1:0] beat
);

    localparam logic [OFS_W-1:0] BEAT_ONE  = OFS_W'(1);
    localparam logic [OFS_W-1:0] OFS_ZERO  = '0;

    bseq_state_e      state_nx;
    logic             do_load;
    logic             do_step;

    assign do_load = (load_src != LD_NONE);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and transition decode
    always_comb begin
        state_nx = state;
        do_step  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (do_load) begin
                    state_nx = ST_BURST;          // T_OPEN
                end
            end
            ST_BURST: begin
                if (do_load) begin
                    state_nx = ST_BURST;          // T_RELOAD
                end else if (!adv_n) begin
                    do_step  = 1'b1;              // T_STEP
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output registers: start offset and beat count
    always_ff @(posedge clk) begin
        if (rst) begin
            start_ofs <= OFS_ZERO;
            beat      <= OFS_ZERO;
        end else if (do_load) begin
            start_ofs <= addr_lo;
            beat      <= OFS_ZERO;
        end else if (do_step) begin
            beat      <= beat + BEAT_ONE;
        end
    end

endmodule

// File: rtl/offset_map.sv
module offset_map #(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] start_ofs,
    input  logic [OFS_W-1:0] beat,
    input  logic             interleave,
    output logic [OFS_W-1:0] ofs
);

    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] xor_ofs;

    assign lin_ofs = start_ofs + beat;

    for (genvar b = 0; b < OFS_W; b++) begin : g_xor_bit
        assign xor_ofs[b] = start_ofs[b] ^ beat[b];
    end

    assign ofs = interleave ? xor_ofs : lin_ofs;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             ce1_n,
    input  logic             adv_n,
    input  logic             burst_order,
    input  logic [OFS_W-1:0] addr_lo,
    output logic [OFS_W-1:0] burst_ofs
);

    load_src_e        load_src;
    bseq_state_e      state;
    logic [OFS_W-1:0] start_ofs;
    logic [OFS_W-1:0] beat;

    strobe_arbiter u_arb (
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .ce1_n    (ce1_n),
        .load_src (load_src)
    );

    burst_fsm #(.OFS_W(OFS_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .load_src  (load_src),
        .adv_n     (adv_n),
        .addr_lo   (addr_lo),
        .state     (state),
        .start_ofs (start_ofs),
        .beat      (beat)
    );

    offset_map #(.OFS_W(OFS_W)) u_map (
        .start_ofs  (start_ofs),
        .beat       (beat),
        .interleave (burst_order),
        .ofs        (burst_ofs)
    );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             adsp_n,
    input logic             adsc_n,
    input logic             ce1_n,
    input logic             adv_n,
    input logic             burst_order,
    input logic [OFS_W-1:0] addr_lo,
    input logic [OFS_W-1:0] burst_ofs,
    input bseq_state_e      state
);

    logic no_strobe;
    assign no_strobe = adsc_n && (adsp_n || ce1_n);

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
        !adsc_n |=> burst_ofs == $past(addr_lo));

    assert_proc_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!adsp_n && !ce1_n) |=> burst_ofs == $past(addr_lo));

    assert_proc_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (!adsp_n && ce1_n && adsc_n && adv_n) |=> $stable(burst_ofs));

    assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BURST && no_strobe && !adv_n && !burst_order && $stable(burst_order))
        |=> burst_ofs == $past(burst_ofs) + OFS_W'(1));

    assert_interleave_step_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BURST && no_strobe && !adv_n && burst_order && $stable(burst_order))
        |=> burst_ofs != $past(burst_ofs));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (no_strobe && adv_n) |=> $stable(burst_ofs));

    assert_idle_adv_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && no_strobe) |=> (burst_ofs == '0 && state == ST_IDLE));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.OFS_W(OFS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .adsp_n      (adsp_n),
    .adsc_n      (adsc_n),
    .ce1_n       (ce1_n),
    .adv_n       (adv_n),
    .burst_order (burst_order),
    .addr_lo     (addr_lo),
    .burst_ofs   (burst_ofs),
    .state       (state)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adsp_n = 1'b1;
    logic       adsc_n = 1'b1;
    logic       ce1_n = 1'b1;
    logic       adv_n = 1'b1;
    logic       burst_order = 1'b0;
    logic [1:0] addr_lo = 2'd0;
    logic [1:0] burst_ofs;

    int errors = 0;
    int checks = 0;

    // Reference model state (from the requirements)
    logic       m_loaded;
    logic [1:0] m_start;
    logic [1:0] m_beat;

    // Scoreboard queues
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq i_burst_addr_seq (
        .clk         (clk),
        .rst         (rst),
        .adsp_n      (adsp_n),
        .adsc_n      (adsc_n),
        .ce1_n       (ce1_n),
        .adv_n       (adv_n),
        .burst_order (burst_order),
        .addr_lo     (addr_lo),
        .burst_ofs   (burst_ofs)
    );

    // Monitor: sample just after each rising edge, compare with queued item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (burst_ofs !== e) begin
                    errors++;
                    $display("FAIL %s: burst_ofs=%0d expected=%0d", t, burst_ofs, e);
                end
            end
        end
    end

    task automatic do_reset(input logic order);
        @(negedge clk);
        rst = 1'b1;
        adsp_n = 1'b1; adsc_n = 1'b1; ce1_n = 1'b1; adv_n = 1'b1;
        burst_order = order;
        repeat (3) @(negedge clk);
        checks++;
        if (burst_ofs !== 2'd0) begin
            errors++;
            $display("FAIL R1: burst_ofs=%0d expected=0 under reset", burst_ofs);
        end
        m_loaded = 1'b0; m_start = 2'd0; m_beat = 2'd0;
        rst = 1'b0;
    endtask

    // Driver: apply one cycle of stimulus and push the expected offset
    task automatic step(input logic p_n, input logic c_n, input logic ce_n,
                        input logic a_n, input logic [1:0] addr, input string tag);
        logic ld;
        @(negedge clk);
        adsp_n = p_n; adsc_n = c_n; ce1_n = ce_n; adv_n = a_n; addr_lo = addr;
        ld = (!p_n && !ce_n) || !c_n;
        if (ld) begin
            m_start = addr; m_beat = 2'd0; m_loaded = 1'b1;
        end else if (!a_n && m_loaded) begin
            m_beat = m_beat + 2'd1;
        end
        exp_q.push_back(burst_order ? (m_start ^ m_beat) : (m_start + m_beat));
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    endtask

    initial begin
        // Linear order
        do_reset(1'b0);
        step(1, 1, 1, 0, 2'd3, "R10 advance in idle");
        step(1, 1, 1, 0, 2'd1, "R10 advance in idle again");
        step(1, 0, 1, 1, 2'd2, "R2 controller load");
        step(1, 1, 1, 0, 2'd0, "R6 linear beat 1");
        step(1, 1, 1, 0, 2'd0, "R6 linear beat 2");
        step(1, 1, 1, 0, 2'd0, "R6 linear beat 3");
        step(1, 1, 1, 0, 2'd0, "R8 linear wrap to start");
        step(1, 1, 1, 0, 2'd0, "R8 linear keeps cycling");
        step(1, 1, 0, 1, 2'd1, "R9 hold");
        step(0, 1, 1, 1, 2'd1, "R4 gated processor strobe");
        step(0, 1, 0, 1, 2'd1, "R3 processor load");
        step(1, 1, 0, 0, 2'd0, "R6 step after processor load");
        step(0, 0, 0, 0, 2'd3, "R5 both strobes plus advance");
        step(1, 1, 0, 0, 2'd0, "R6 step after dual strobe");
        step(0, 0, 1, 1, 2'd0, "R11 controller load with chip enable off");
        step(1, 0, 1, 0, 2'd2, "R5 controller strobe beats advance");
        drain();

        // Interleaved order
        do_reset(1'b1);
        step(1, 1, 1, 0, 2'd2, "R10 advance in idle interleaved");
        step(1, 0, 1, 1, 2'd1, "R2 controller load interleaved");
        step(1, 1, 1, 0, 2'd0, "R7 interleaved beat 1");
        step(1, 1, 1, 0, 2'd0, "R7 interleaved beat 2");
        step(1, 1, 1, 0, 2'd0, "R7 interleaved beat 3");
        step(1, 1, 1, 0, 2'd0, "R8 interleaved wrap");
        step(1, 1, 1, 0, 2'd0, "R8 interleaved keeps cycling");
        step(0, 1, 0, 1, 2'd2, "R3 processor load interleaved");
        step(1, 1, 1, 0, 2'd0, "R7 interleaved from 2 beat 1");
        step(1, 1, 1, 0, 2'd0, "R7 interleaved from 2 beat 2");
        step(1, 1, 1, 1, 2'd3, "R9 hold interleaved");
        step(1, 1, 1, 0, 2'd0, "R7 interleaved from 2 beat 3");
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule